// File: doc/BRIEF.md
# Linked Parameter-Set Transfer Sequencer

This block turns synchronization events into a stream of copy requests. Software writes transfer sets into a small parameter RAM through a word-wide write/read port. Set 0 is the working set. Each event makes the engine handle the next slice of set 0 and send one request per array on a valid/ready interface. A request gives a source address, a destination address and a byte count.

A set describes a three-level walk: bytes per array, arrays per frame and frames per block. Array-to-array and frame-to-frame steps are signed. An option bit chooses one of two event granularities. In the first, each event moves one array. In the second, each event moves a whole frame. The engine writes its progress back into set 0, so the cfg port always shows the remaining work.

When the last slice is accepted, the engine pulses a completion strobe that carries a code from the options word. It then replaces set 0 with the set that the link field names. If there is no link, it clears set 0, and any later event is refused with an error pulse.

Top module: `lps_xfer_seq`

## Requirements
- R1: After reset every set reads back with word 5 = 0x0000FFFF, word 7 = 0x00000001 and all other words zero, and req_valid, cmpl_pulse and null_err are low.
- R2: cfg_addr selects set cfg_addr[6:3] and word cfg_addr[2:0], and a write is visible on cfg_rdata from the next cycle. The word layout is:
  - word 0: options. bit0 fixes the source, bit1 fixes the destination, bit2 selects frame mode, bits 10:8 hold the FIFO width code and bits 17:12 hold the completion code.
  - word 1: source address. word 3: destination address.
  - word 2: array size in bits 15:0 and array count in bits 31:16.
  - word 4: array steps, with the source step in bits 15:0 and the destination step in bits 31:16.
  - word 5: link in bits 15:0 and array-count reload in bits 31:16.
  - word 6: frame steps, in the same layout as word 4.
  - word 7: frame count in bits 15:0.
- R3: In array mode (bit2 clear), each event gives exactly one request, whose length is the array size and whose addresses are those held in set 0. If the array count is above 1, set 0 then advances its addresses by the array steps and decrements the array count.
- R4: In array mode, when the array count is 1 and the frame count is above 1, the addresses advance by the frame steps from the last array, the array count is reloaded from word 5 bits 31:16, and the frame count decrements.
- R5: In frame mode, one event gives array-count requests. Request k is at the frame start plus k times the array step. The frame start then advances by the frame step, and the frame count decrements.
- R6: A fixed source (or destination) address never advances. Requests carry req_sfix, req_dfix and the width code from option bits 10:8.
- R7: Accepting the final request of a set raises cmpl_pulse for exactly one cycle, in the cycle after the handshake, with cmpl_code equal to option bits 17:12. No pulse follows any other request.
- R8: At completion, if the link is not 0xFFFF, set 0 is replaced by the set at index link/32 before the next event is taken.
- R9: At completion with a link of 0xFFFF, set 0 becomes all zeros. An event finding any count at zero raises null_err for one cycle and issues no request.
- R10: An event that arrives while the engine is busy is held, one deep. A further event while one is held is dropped.
- R11: While req_valid is high and req_ready is low, req_valid, req_src, req_dst and req_len hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Parameter RAM write strobe |
| cfg_addr | input | 7 | Word address: set in bits 6:3, word in bits 2:0 |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data |
| sync_evt | input | 1 | Synchronization event |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted |
| req_src | output | 32 | Request source address |
| req_dst | output | 32 | Request destination address |
| req_len | output | 16 | Request byte count |
| req_sfix | output | 1 | Source address is fixed |
| req_dfix | output | 1 | Destination address is fixed |
| req_fwid | output | 3 | FIFO width code |
| cmpl_pulse | output | 1 | Set completed |
| cmpl_code | output | 6 | Completion code |
| null_err | output | 1 | Event refused on an empty set |

## Verification
The hardest state to reach is the one-deep event hold under back-pressure. The engine must be busy mid-frame, with one event already held, when a third event arrives. The stimulus gets there by holding req_ready low and pulsing the event on three consecutive cycles. It then releases req_ready and checks three things: exactly two requests appear, no third request follows, and the array count read back from set 0 shows exactly two arrays consumed. A chained run then covers the link handling. It reloads set 0 from set 3, drains that set, and checks that the cleared set refuses the next event.

// File: rtl/lps_pkg.sv
`timescale 1ns/1ps
package lps_pkg;
  localparam int WORDS   = 8;
  localparam int WI_OPT  = 0;
  localparam int WI_SRC  = 1;
  localparam int WI_CNT  = 2;
  localparam int WI_DST  = 3;
  localparam int WI_BIX  = 4;
  localparam int WI_LNK  = 5;
  localparam int WI_CIX  = 6;
  localparam int WI_CCN  = 7;
  localparam int OB_SFIX = 0;
  localparam int OB_DFIX = 1;
  localparam int OB_FRM  = 2;
  localparam int FW_LO   = 8;
  localparam int FW_W    = 3;
  localparam int TC_LO   = 12;
  localparam int TC_W    = 6;
  localparam logic [15:0] NO_LINK = 16'hFFFF;

  typedef logic [WORDS-1:0][31:0] pset_t;
  typedef enum logic {ST_IDLE, ST_ISSUE} eng_st_t;

  function automatic pset_t default_set();
    pset_t s;
    s = '0;
    s[WI_LNK] = {16'h0000, NO_LINK};
    s[WI_CCN] = 32'd1;
    return s;
  endfunction

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
endpackage

// File: rtl/lps_pram.sv
`timescale 1ns/1ps
module lps_pram
  import lps_pkg::*;
#(
  parameter int NSETS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [$clog2(NSETS)+2:0]    cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  output logic [31:0]                 cfg_rdata,
  input  logic                        upd_we,
  input  pset_t                       upd_val,
  input  logic [$clog2(NSETS)-1:0]    lnk_idx,
  output pset_t                       lnk_set,
  output pset_t                       wk_set
);
  localparam int SW = $clog2(NSETS);
  localparam int AW = SW + 3;

  pset_t            sets [NSETS];
  logic [SW-1:0]    cfg_set;
  logic [2:0]       cfg_word;

  assign cfg_set  = cfg_addr[AW-1:3];
  assign cfg_word = cfg_addr[2:0];

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    localparam bit IS_WK = (s == 0);
    pset_t q, d;
    logic  hit, en;

    assign hit = cfg_we && (cfg_set == SW'(s));
    assign en  = hit || (IS_WK && upd_we);

    always_comb begin
      d = q;
      if (hit) d[cfg_word] = cfg_wdata;
      if (IS_WK && upd_we) d = upd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= default_set();
      else if (en) q <= d;
    end

    assign sets[s] = q;
  end

  assign cfg_rdata = sets[cfg_set][cfg_word];
  assign lnk_set   = sets[lnk_idx];
  assign wk_set    = sets[0];

  // R2: a write to a set the engine never touches lands in the addressed word
  a_r2_cfg_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_set != '0) |=> sets[$past(cfg_set)][$past(cfg_word)] == $past(cfg_wdata));
endmodule

// File: rtl/lps_evq.sv
`timescale 1ns/1ps
module lps_evq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (take_i) pend_d = 1'b0;
    if (evt_i)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R10: an event is never lost while the slot is free or being emptied
  a_r10_evt_held: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> pend_o);
  // R10: a held event waits until the engine takes it
  a_r10_wait_take: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o && !take_i |=> pend_o);
endmodule

// File: rtl/lps_engine.sv
`timescale 1ns/1ps
module lps_engine
  import lps_pkg::*;
#(
  parameter int NSETS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  pset_t                    wk,
  input  logic                     pend,
  output logic                     take,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [31:0]              req_src,
  output logic [31:0]              req_dst,
  output logic [15:0]              req_len,
  output logic                     req_sfix,
  output logic                     req_dfix,
  output logic [FW_W-1:0]          req_fwid,
  output logic                     upd_we,
  output pset_t                    upd_val,
  output logic [$clog2(NSETS)-1:0] lnk_idx,
  input  pset_t                    lnk_set,
  output logic                     done_o,
  output logic [TC_W-1:0]          done_code,
  output logic                     err_o
);
  localparam int SW = $clog2(NSETS);

  eng_st_t         state_q, state_d;
  logic [31:0]     src_q, src_d, dst_q, dst_d;
  logic [15:0]     left_q, left_d;
  logic            done_q, done_d, err_q, err_d;
  logic [TC_W-1:0] code_q, code_d;

  logic [31:0] opt;
  logic [15:0] acnt, bcnt, ccnt, brld, link;
  logic        sfix, dfix, frame_mode, is_null;
  logic [31:0] s_bstep, d_bstep, s_cstep, d_cstep;

  assign opt        = wk[WI_OPT];
  assign acnt       = wk[WI_CNT][15:0];
  assign bcnt       = wk[WI_CNT][31:16];
  assign ccnt       = wk[WI_CCN][15:0];
  assign brld       = wk[WI_LNK][31:16];
  assign link       = wk[WI_LNK][15:0];
  assign sfix       = opt[OB_SFIX];
  assign dfix       = opt[OB_DFIX];
  assign frame_mode = opt[OB_FRM];
  assign is_null    = (acnt == 16'd0) || (bcnt == 16'd0) || (ccnt == 16'd0);
  assign s_bstep    = sfix ? 32'd0 : sext16(wk[WI_BIX][15:0]);
  assign d_bstep    = dfix ? 32'd0 : sext16(wk[WI_BIX][31:16]);
  assign s_cstep    = sfix ? 32'd0 : sext16(wk[WI_CIX][15:0]);
  assign d_cstep    = dfix ? 32'd0 : sext16(wk[WI_CIX][31:16]);
  assign lnk_idx    = link[SW+4:5];

  logic unused_fields;
  assign unused_fields = ^{opt[31:TC_LO+TC_W], opt[FW_LO-1:OB_FRM+1], opt[TC_LO-1:FW_LO+FW_W],
                           wk[WI_CCN][31:16], link[15:SW+5], link[4:0]};

  assign take = (state_q == ST_IDLE) && pend;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    left_d  = left_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    code_d  = code_q;
    upd_we  = 1'b0;
    upd_val = wk;
    unique case (state_q)
      ST_IDLE: begin
        if (pend) begin
          if (is_null) begin
            err_d = 1'b1;
          end else begin
            state_d = ST_ISSUE;
            src_d   = wk[WI_SRC];
            dst_d   = wk[WI_DST];
            left_d  = frame_mode ? bcnt : 16'd1;
          end
        end
      end
      ST_ISSUE: begin
        if (req_ready) begin
          src_d  = src_q + s_bstep;
          dst_d  = dst_q + d_bstep;
          left_d = left_q - 16'd1;
          if (left_q == 16'd1) begin
            state_d = ST_IDLE;
            upd_we  = 1'b1;
            if (!frame_mode && (bcnt > 16'd1)) begin
              upd_val[WI_SRC]        = wk[WI_SRC] + s_bstep;
              upd_val[WI_DST]        = wk[WI_DST] + d_bstep;
              upd_val[WI_CNT][31:16] = bcnt - 16'd1;
            end else if (ccnt > 16'd1) begin
              upd_val[WI_SRC]       = wk[WI_SRC] + s_cstep;
              upd_val[WI_DST]       = wk[WI_DST] + d_cstep;
              upd_val[WI_CCN][15:0] = ccnt - 16'd1;
              if (!frame_mode) upd_val[WI_CNT][31:16] = brld;
            end else begin
              done_d  = 1'b1;
              code_d  = opt[TC_LO +: TC_W];
              upd_val = (link == NO_LINK) ? '0 : lnk_set;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      left_q  <= left_d;
      done_q  <= done_d;
      err_q   <= err_d;
      code_q  <= code_d;
    end
  end

  assign req_valid = (state_q == ST_ISSUE);
  assign req_src   = src_q;
  assign req_dst   = dst_q;
  assign req_len   = acnt;
  assign req_sfix  = sfix;
  assign req_dfix  = dfix;
  assign req_fwid  = opt[FW_LO +: FW_W];
  assign done_o    = done_q;
  assign done_code = code_q;
  assign err_o     = err_q;

  // R11: a stalled request holds its content
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_len));
  // R3: every issued request moves at least one byte
  a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_len != 16'd0);
  // R6: a fixed source address stays put across back-to-back requests
  a_r6_fixed_src: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_sfix && $past(req_valid) |-> $stable(req_src));
  // R7: the completion strobe lasts one cycle and never overlaps a request
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid);
  // R9: a refused event issues nothing
  a_r9_err_noreq: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !req_valid && !done_o);
endmodule

// File: rtl/lps_xfer_seq.sv
`timescale 1ns/1ps
module lps_xfer_seq
  import lps_pkg::*;
#(
  parameter int NSETS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NSETS)+2:0] cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  input  logic                     sync_evt,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [31:0]              req_src,
  output logic [31:0]              req_dst,
  output logic [15:0]              req_len,
  output logic                     req_sfix,
  output logic                     req_dfix,
  output logic [2:0]               req_fwid,
  output logic                     cmpl_pulse,
  output logic [5:0]               cmpl_code,
  output logic                     null_err
);
  localparam int SW = $clog2(NSETS);

  pset_t         wk_set, upd_val, lnk_set;
  logic          upd_we, pend, take;
  logic [SW-1:0] lnk_idx;

  lps_pram #(.NSETS(NSETS)) u_pram (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .upd_we    (upd_we),
    .upd_val   (upd_val),
    .lnk_idx   (lnk_idx),
    .lnk_set   (lnk_set),
    .wk_set    (wk_set)
  );

  lps_evq u_evq (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (sync_evt),
    .take_i (take),
    .pend_o (pend)
  );

  lps_engine #(.NSETS(NSETS)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .wk        (wk_set),
    .pend      (pend),
    .take      (take),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_src   (req_src),
    .req_dst   (req_dst),
    .req_len   (req_len),
    .req_sfix  (req_sfix),
    .req_dfix  (req_dfix),
    .req_fwid  (req_fwid),
    .upd_we    (upd_we),
    .upd_val   (upd_val),
    .lnk_idx   (lnk_idx),
    .lnk_set   (lnk_set),
    .done_o    (cmpl_pulse),
    .done_code (cmpl_code),
    .err_o     (null_err)
  );
endmodule

// File: tb/lps_xfer_seq_test.sv
`timescale 1ns/1ps
module lps_xfer_seq_test;
  typedef struct packed {
    logic [31:0] opt;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] acnt, bcnt, ccnt, brld, sbidx, dbidx, scidx, dcidx;
    logic [7:0]  nreq;
    logic        stall;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_5000, 32'h1000, 32'h2000, 16'd16, 16'd3, 16'd2, 16'd2, 16'h0010, 16'h0020, 16'h0100, 16'hFFC0, 8'd5,  1'b0},
    '{32'h0000_9004, 32'h8000, 32'h9000, 16'd8,  16'd4, 16'd3, 16'd0, 16'h0008, 16'hFFF8, 16'h0040, 16'h0080, 8'd12, 1'b1},
    '{32'h0000_C305, 32'hA000, 32'hB000, 16'd4,  16'd2, 16'd2, 16'd0, 16'h0004, 16'h0004, 16'h0004, 16'h0010, 8'd4,  1'b0},
    '{32'h0003_F102, 32'hC000, 32'hD000, 16'd2,  16'd1, 16'd3, 16'd1, 16'h0002, 16'h0000, 16'h0006, 16'h0000, 8'd3,  1'b0}
  };

  logic        clk, rst_n, cfg_we, sync_evt, req_ready;
  logic [6:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata, req_src, req_dst;
  logic [15:0] req_len;
  logic        req_valid, req_sfix, req_dfix, cmpl_pulse, null_err;
  logic [2:0]  req_fwid;
  logic [5:0]  cmpl_code;
  int n_chk, n_fail;

  lps_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sync_evt(sync_evt), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_len(req_len), .req_sfix(req_sfix),
    .req_dfix(req_dfix), .req_fwid(req_fwid), .cmpl_pulse(cmpl_pulse), .cmpl_code(cmpl_code),
    .null_err(null_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int set, input int word, input logic [31:0] data);
    @(negedge clk);
    cfg_addr = 7'(set * 8 + word); cfg_wdata = data; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int set, input int word, output logic [31:0] data);
    cfg_addr = 7'(set * 8 + word);
    #1;
    data = cfg_rdata;
  endtask

  task automatic fire();
    @(negedge clk); sync_evt = 1'b1;
    @(negedge clk); sync_evt = 1'b0;
  endtask

  task automatic expect_req(input logic [31:0] es, input logic [31:0] ed, input logic [15:0] el,
                            input logic sf, input logic df, input logic [2:0] fw, input string tag);
    int i;
    for (i = 0; i < 40 && !req_valid; i++) @(negedge clk);
    chk(req_valid && req_src == es && req_dst == ed && req_len == el &&
        req_sfix == sf && req_dfix == df && req_fwid == fw, tag,
        {req_src, req_dst}, {es, ed});
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_entry(input int idx);
    vec_t v;
    logic [31:0] s, d, sb, db, sc, dc, hs;
    logic [15:0] b, c;
    bit fin, frm, sf, df, first;
    int nr;
    v = TBL[idx];
    wr(0, 0, v.opt); wr(0, 1, v.src); wr(0, 2, {v.bcnt, v.acnt}); wr(0, 3, v.dst);
    wr(0, 4, {v.dbidx, v.sbidx}); wr(0, 5, {v.brld, 16'hFFFF});
    wr(0, 6, {v.dcidx, v.scidx}); wr(0, 7, {16'd0, v.ccnt});
    s = v.src; d = v.dst; b = v.bcnt; c = v.ccnt;
    sb = {{16{v.sbidx[15]}}, v.sbidx}; db = {{16{v.dbidx[15]}}, v.dbidx};
    sc = {{16{v.scidx[15]}}, v.scidx}; dc = {{16{v.dcidx[15]}}, v.dcidx};
    frm = v.opt[2]; sf = v.opt[0]; df = v.opt[1];
    fin = 0; nr = 0; first = 1;
    if (v.stall) req_ready = 1'b0;
    while (!fin) begin
      fire();
      if (first && v.stall) begin
        // R11: stalled request must hold
        for (int i = 0; i < 40 && !req_valid; i++) @(negedge clk);
        hs = req_src;
        @(negedge clk); @(negedge clk);
        chk(req_valid && req_src == hs, "R11 stalled request held", {31'd0, req_valid, req_src}, {32'd1, hs});
        req_ready = 1'b1;
      end
      first = 0;
      if (frm) begin
        for (int k = 0; k < int'(b); k++) begin
          expect_req(s + (sf ? 32'd0 : 32'(k) * sb), d + (df ? 32'd0 : 32'(k) * db),
                     v.acnt, sf, df, v.opt[10:8], "R5/R6 frame-mode request");
          nr++;
        end
        if (c > 1) begin
          if (!sf) s = s + sc;
          if (!df) d = d + dc;
          c = c - 1;
        end else fin = 1;
      end else begin
        expect_req(s, d, v.acnt, sf, df, v.opt[10:8], "R3/R4/R6 array-mode request");
        nr++;
        if (b > 1) begin
          if (!sf) s = s + sb;
          if (!df) d = d + db;
          b = b - 1;
        end else if (c > 1) begin
          if (!sf) s = s + sc;
          if (!df) d = d + dc;
          b = v.brld; c = c - 1;
        end else fin = 1;
      end
      if (!fin) chk(cmpl_pulse == 1'b0, "R7 no pulse mid-set", 64'(cmpl_pulse), 64'd0);
    end
    chk(cmpl_pulse == 1'b1 && cmpl_code == v.opt[17:12], "R7 completion pulse and code",
        {cmpl_pulse, cmpl_code}, {1'b1, v.opt[17:12]});
    chk(nr == int'(v.nreq), "R3/R5 request count", 64'(nr), 64'(v.nreq));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; sync_evt = 1'b0; req_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents and idle outputs
    rd(5, 5, r); chk(r == 32'h0000FFFF, "R1 reset link word", 64'(r), 64'h0000FFFF);
    rd(5, 7, r); chk(r == 32'd1, "R1 reset frame count", 64'(r), 64'd1);
    rd(5, 0, r); chk(r == 32'd0, "R1 reset options", 64'(r), 64'd0);
    chk(!req_valid && !cmpl_pulse && !null_err, "R1 idle outputs",
        {req_valid, cmpl_pulse, null_err}, 64'd0);

    // R2: word write/read addressing
    wr(9, 4, 32'hDEADBEEF);
    rd(9, 4, r); chk(r == 32'hDEADBEEF, "R2 write readback", 64'(r), 64'hDEADBEEF);
    rd(9, 3, r); chk(r == 32'd0, "R2 neighbour untouched", 64'(r), 64'd0);

    // table of transfers, each ending with a null link
    for (int i = 0; i < NV; i++) run_entry(i);

    // R8: link reload from set 3
    wr(3, 0, 32'h0000_7000); wr(3, 1, 32'h3000); wr(3, 2, {16'd2, 16'd4}); wr(3, 3, 32'h4000);
    wr(3, 4, {16'd4, 16'd4}); wr(3, 5, 32'h0000FFFF); wr(3, 6, 32'd0); wr(3, 7, 32'd1);
    wr(0, 0, 32'h0000_2004); wr(0, 1, 32'h10); wr(0, 2, {16'd1, 16'd1}); wr(0, 3, 32'h20);
    wr(0, 4, 32'd0); wr(0, 5, 32'h0000_0060); wr(0, 6, 32'd0); wr(0, 7, 32'd1);
    fire();
    expect_req(32'h10, 32'h20, 16'd1, 1'b0, 1'b0, 3'd0, "R5 linked-from set");
    chk(cmpl_pulse && cmpl_code == 6'd2, "R7 code of first set", {cmpl_pulse, cmpl_code}, {1'b1, 6'd2});
    @(negedge clk);
    rd(0, 1, r); chk(r == 32'h3000, "R8 set 0 reloaded source", 64'(r), 64'h3000);
    rd(0, 2, r); chk(r == {16'd2, 16'd4}, "R8 set 0 reloaded counts", 64'(r), 64'h00020004);
    fire();
    expect_req(32'h3000, 32'h4000, 16'd4, 1'b0, 1'b0, 3'd0, "R8 linked set array 0");
    fire();
    expect_req(32'h3004, 32'h4004, 16'd4, 1'b0, 1'b0, 3'd0, "R8 linked set array 1");
    chk(cmpl_pulse && cmpl_code == 6'd7, "R8 linked set completion code", {cmpl_pulse, cmpl_code}, {1'b1, 6'd7});

    // R9: cleared set refuses events
    @(negedge clk);
    rd(0, 7, r); chk(r == 32'd0, "R9 cleared frame count", 64'(r), 64'd0);
    rd(0, 5, r); chk(r == 32'd0, "R9 cleared link word", 64'(r), 64'd0);
    begin
      bit seen_err, seen_req;
      seen_err = 0; seen_req = 0;
      fire();
      for (int i = 0; i < 10; i++) begin
        if (null_err) seen_err = 1;
        if (req_valid) seen_req = 1;
        @(negedge clk);
      end
      chk(seen_err, "R9 null error raised", 64'(seen_err), 64'd1);
      chk(!seen_req, "R9 no request on null set", 64'(seen_req), 64'd0);
    end

    // R10: one-deep hold, extra events dropped
    wr(0, 0, 32'h0000_1000); wr(0, 1, 32'h500); wr(0, 2, {16'd4, 16'd8}); wr(0, 3, 32'h600);
    wr(0, 4, {16'd8, 16'd8}); wr(0, 5, 32'h0000FFFF); wr(0, 6, 32'd0); wr(0, 7, 32'd1);
    req_ready = 1'b0;
    @(negedge clk); sync_evt = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk); sync_evt = 1'b0;
    @(negedge clk); @(negedge clk);
    req_ready = 1'b1;
    expect_req(32'h500, 32'h600, 16'd8, 1'b0, 1'b0, 3'd0, "R10 first event");
    expect_req(32'h508, 32'h608, 16'd8, 1'b0, 1'b0, 3'd0, "R10 held event");
    begin
      bit extra;
      extra = 0;
      for (int i = 0; i < 20; i++) begin
        if (req_valid) extra = 1;
        @(negedge clk);
      end
      chk(!extra, "R10 third event dropped", 64'(extra), 64'd0);
    end
    rd(0, 2, r); chk(r[31:16] == 16'd2, "R10 two arrays consumed", 64'(r[31:16]), 64'd2);
    rd(0, 1, r); chk(r == 32'h510, "R3 source advanced by array step", 64'(r), 64'h510);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule